// File: doc/BRIEF.md
# Page-Mode Parallel ROM Burst Reader

This block sits between a synchronous fabric and an asynchronous parallel ROM. The ROM has two organisations, 16-bit words or 8-bit bytes, and a fast page feature: once the upper address is settled, any location inside the same aligned page can be read after a much shorter delay. The host asks for a burst by giving a start location, a beat count and the organisation on a valid/ready request port. The block enables the ROM, steps through consecutive locations and returns each datum on a valid/ready stream whose last beat is flagged.

Every ROM delay is a whole number of clock cycles set by a parameter. The first location of a burst waits the longer of the random-access and output-enable delays. A location in the same page as the previous one waits only the page delay. A location in a new page waits the random-access delay again. In byte organisation the least significant location bit goes out on a separate pin, which on the ROM shares a pad with the top data bit. The returned byte is zero-extended. Between bursts both enables are released, and no new request is taken until the bus-release delay has passed.

Top module: `prom_page_rd`

## Requirements
- R1: During reset and after it, rom_ce_n and rom_oe_n are high and out_valid is low. req_ready stays low for T_HIZ cycles after reset is released, then goes high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. From the next cycle rom_ce_n and rom_oe_n are low and req_ready is low.
- R3: The first beat of a burst becomes valid max(T_RAND, T_OE) cycles after the edge that took the request.
- R4: A beat whose location is in the same page as the previous beat becomes valid T_PAGE cycles after the edge that accepted the previous beat.
- R5: A beat whose location is in a different page from the previous beat becomes valid T_RAND cycles after the edge that accepted the previous beat.
- R6: Word organisation (req_byte low): rom_wide is 1 and rom_lsb_en is 0. rom_addr carries the low RAW bits of the location, and out_data is rom_q as sampled.
- R7: Byte organisation (req_byte high): rom_wide is 0 and rom_lsb_en is 1. rom_addr carries the location shifted right by one, rom_lsb carries location bit 0, and out_data is rom_q[7:0] with all upper bits zero.
- R8: The location advances by one per beat and wraps at the top of the address range. A page is 2^PAGE_BITS locations in word organisation and 2^(PAGE_BITS+1) in byte organisation, aligned to its own size.
- R9: A burst has req_len+1 beats. out_last is high on the final beat only.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_last and rom_addr hold their values.
- R11: In the cycle after the final beat is accepted, rom_ce_n and rom_oe_n are high. req_ready stays low for T_HIZ cycles and then goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Burst request can be taken |
| req_addr | input | RAW+1 | Start location (word index, or byte index in byte organisation) |
| req_len | input | LEN_W | Beat count minus one |
| req_byte | input | 1 | 1 selects byte organisation, 0 selects word organisation |
| out_valid | output | 1 | Beat data present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DW | Beat data, zero-extended in byte organisation |
| out_last | output | 1 | Final beat of the burst |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_wide | output | 1 | ROM organisation select, 1 = word |
| rom_addr | output | RAW | ROM address pins |
| rom_lsb | output | 1 | Byte-select address bit (shared data pad) |
| rom_lsb_en | output | 1 | Drive enable for rom_lsb |
| rom_q | input | DW | ROM data pins |

## Verification
Two things can happen in the same clock cycle: the consumer accepts a beat, and the block decides whether the next location leaves the current page. That decision sets the next wait to either the page delay or the random-access delay. Sweeps start bursts at every offset of a page in both organisations, and at the top of the address range. This puts acceptances at every position relative to a page boundary, some of them after stalls. The bench times each beat in cycles against the page arithmetic. It also uses a ROM model that returns a poison value when sampled before its delays have passed.

// File: rtl/prom_pkg.sv
package prom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACCESS  = 2'd1,
      ST_HOLD    = 2'd2,
      ST_RECOVER = 2'd3
   } prom_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
   parameter int CW      = 4,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   initial begin
      if (CW < 1) $error("prom_wait_timer: CW must be at least 1");
      if (RST_VAL < 0 || RST_VAL >= (1 << CW)) $error("prom_wait_timer: RST_VAL out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= CW'(RST_VAL);
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/prom_addr_gen.sv
module prom_addr_gen #(
   parameter int RAW       = 21,
   parameter int PAGE_BITS = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [RAW:0]   load_loc,
   input  logic           step,
   input  logic           byte_mode,
   output logic [RAW-1:0] rom_addr,
   output logic           rom_lsb,
   output logic           step_crosses
);

   localparam int WOFF = PAGE_BITS;
   localparam int BOFF = PAGE_BITS + 1;

   logic [RAW:0] loc_q;
   logic         word_edge;
   logic         byte_edge;

   initial begin
      if (PAGE_BITS < 1 || PAGE_BITS >= RAW) $error("prom_addr_gen: PAGE_BITS must be in 1..RAW-1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     loc_q <= '0;
      else if (load)  loc_q <= load_loc;
      else if (step)  loc_q <= loc_q + 1'b1;
   end

   // Page edges: the offset field is all ones, so the next step leaves the page.
   assign word_edge = &loc_q[WOFF-1:0];
   assign byte_edge = &loc_q[BOFF-1:0];

   always_comb begin
      if (byte_mode) begin
         rom_addr     = loc_q[RAW:1];
         rom_lsb      = loc_q[0];
         step_crosses = byte_edge;
      end else begin
         rom_addr     = loc_q[RAW-1:0];
         rom_lsb      = 1'b0;
         step_crosses = word_edge;
      end
   end

endmodule

// File: rtl/prom_capture.sv
module prom_capture #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          wide,
   input  logic [DW-1:0] rom_q,
   output logic [DW-1:0] data
);

   localparam int LANES = DW / 8;

   initial begin
      if (DW < 16 || (DW % 8) != 0) $error("prom_capture: DW must be a multiple of 8, at least 16");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q;
      if (g == 0) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   lane_q <= '0;
            else if (en)  lane_q <= rom_q[7:0];
         end
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   lane_q <= '0;
            else if (en)  lane_q <= wide ? rom_q[g*8 +: 8] : 8'h00;
         end
      end
      assign data[g*8 +: 8] = lane_q;
   end

endmodule

// File: rtl/prom_page_rd.sv
module prom_page_rd
   import prom_pkg::*;
#(
   parameter int RAW       = 21,
   parameter int DW        = 16,
   parameter int PAGE_BITS = 3,
   parameter int LEN_W     = 8,
   parameter int T_RAND    = 13,
   parameter int T_PAGE    = 4,
   parameter int T_OE      = 4,
   parameter int T_HIZ     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [RAW:0]     req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_byte,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [DW-1:0]    out_data,
   output logic             out_last,
   output logic             rom_ce_n,
   output logic             rom_oe_n,
   output logic             rom_wide,
   output logic [RAW-1:0]   rom_addr,
   output logic             rom_lsb,
   output logic             rom_lsb_en,
   input  logic [DW-1:0]    rom_q
);

   localparam int T_FIRST = imax(T_RAND, T_OE);
   localparam int T_MAX   = imax(imax(T_FIRST, T_PAGE), T_HIZ);
   localparam int CW      = $clog2(T_MAX + 1);

   initial begin
      if (T_RAND < 1 || T_PAGE < 1 || T_OE < 1 || T_HIZ < 1) $error("prom_page_rd: wait parameters must be at least 1");
      if (T_PAGE > T_RAND) $error("prom_page_rd: page wait exceeds random wait");
      if (LEN_W < 1) $error("prom_page_rd: LEN_W must be at least 1");
   end

   prom_state_e      state_q, state_d;
   logic [LEN_W-1:0] remain_q;
   logic             byte_q;
   logic             en_q;
   logic             valid_q;
   logic             last_q;

   logic             tmr_load;
   logic [CW-1:0]    tmr_val;
   logic             tmr_done;
   logic             loc_load;
   logic             loc_step;
   logic             cap_en;
   logic             crosses;
   logic             take_req;
   logic             take_beat;

   assign take_req  = (state_q == ST_IDLE) && req_valid;
   assign take_beat = (state_q == ST_HOLD) && out_ready;

   prom_wait_timer #(.CW(CW), .RST_VAL(T_HIZ - 1)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   prom_addr_gen #(.RAW(RAW), .PAGE_BITS(PAGE_BITS)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (loc_load),
      .load_loc     (req_addr),
      .step         (loc_step),
      .byte_mode    (byte_q),
      .rom_addr     (rom_addr),
      .rom_lsb      (rom_lsb),
      .step_crosses (crosses)
   );

   prom_capture #(.DW(DW)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cap_en),
      .wide  (!byte_q),
      .rom_q (rom_q),
      .data  (out_data)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      loc_load = 1'b0;
      loc_step = 1'b0;
      cap_en   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               loc_load = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_FIRST - 1);
               state_d  = ST_ACCESS;
            end
         end
         ST_ACCESS: begin
            if (tmr_done) begin
               cap_en  = 1'b1;
               state_d = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (out_ready) begin
               tmr_load = 1'b1;
               if (remain_q == '0) begin
                  tmr_val = CW'(T_HIZ - 1);
                  state_d = ST_RECOVER;
               end else begin
                  loc_step = 1'b1;
                  tmr_val  = crosses ? CW'(T_RAND - 1) : CW'(T_PAGE - 1);
                  state_d  = ST_ACCESS;
               end
            end
         end
         default: begin
            if (tmr_done) state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RECOVER;
         remain_q <= '0;
         byte_q   <= 1'b0;
         en_q     <= 1'b0;
         valid_q  <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take_req) begin
            remain_q <= req_len;
            byte_q   <= req_byte;
            en_q     <= 1'b1;
         end
         if (take_beat) begin
            valid_q <= 1'b0;
            if (remain_q == '0) en_q <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
         end
         if (cap_en) begin
            valid_q <= 1'b1;
            last_q  <= (remain_q == '0);
         end
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign out_valid  = valid_q;
   assign out_last   = last_q;
   assign rom_ce_n   = !en_q;
   assign rom_oe_n   = !en_q;
   assign rom_wide   = !byte_q;
   assign rom_lsb_en = en_q && byte_q;

   // Checker state: cycles the enabled ROM has seen a steady address.
   logic [RAW:0]  chk_loc_q;
   logic [CW-1:0] chk_steady_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_loc_q    <= '0;
         chk_steady_q <= '0;
      end else begin
         chk_loc_q <= {rom_addr, rom_lsb};
         if (rom_ce_n || ({rom_addr, rom_lsb} != chk_loc_q)) chk_steady_q <= '0;
         else if (chk_steady_q != '1)                        chk_steady_q <= chk_steady_q + 1'b1;
      end
   end

   p_accept_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!rom_ce_n && !rom_oe_n && !req_ready));

   p_page_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (chk_steady_q >= CW'(T_PAGE - 1)));

   p_byte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !rom_wide) |-> (out_data[DW-1:8] == '0));

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(rom_addr)));

   p_last_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (rom_ce_n && rom_oe_n && !req_ready));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rom_ce_n && rom_oe_n && !out_valid));

endmodule

// File: tb/prom_page_rd_test.sv
module prom_page_rd_test;

   localparam int RAW = 6, DW = 16, PB = 3, LEN_W = 5;
   localparam int TR = 13, TP = 4, TO = 4, TH = 3;
   localparam int TF = (TR > TO) ? TR : TO;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_byte = 1'b0, out_ready = 1'b0;
   logic [RAW:0] req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic req_ready, out_valid, out_last, rom_ce_n, rom_oe_n, rom_wide, rom_lsb, rom_lsb_en;
   logic [DW-1:0] out_data, rom_q;
   logic [RAW-1:0] rom_addr;

   int errors = 0, checks = 0, wd = 0;

   prom_page_rd #(.RAW(RAW), .DW(DW), .PAGE_BITS(PB), .LEN_W(LEN_W),
                  .T_RAND(TR), .T_PAGE(TP), .T_OE(TO), .T_HIZ(TH)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_wide(rom_wide), .rom_addr(rom_addr),
      .rom_lsb(rom_lsb), .rom_lsb_en(rom_lsb_en), .rom_q(rom_q));

   always #4 clk = ~clk;

   function automatic logic [15:0] wval(input int a);
      return 16'((a % (1 << RAW)) * 40503) ^ 16'h5A5A;
   endfunction

   // ROM model: poison value until each delay has elapsed since the relevant change.
   logic [RAW+1:0] up_prev = '1;
   logic [3:0] off_prev = '1;
   logic oe_prev = 1'b1;
   int rc = 0, pc = 0, oc = 0;
   logic [RAW+1:0] up_now;
   logic [3:0] off_now;
   logic [15:0] wsel;
   assign up_now  = {rom_ce_n, rom_wide, rom_addr[RAW-1:PB]};
   assign off_now = {rom_addr[PB-1:0], rom_lsb & rom_lsb_en};
   assign wsel    = wval(int'(rom_addr));
   always @(negedge clk) begin
      rc <= (up_now != up_prev) ? 0 : rc + 1;
      pc <= (off_now != off_prev) ? 0 : pc + 1;
      oc <= (rom_oe_n != oe_prev) ? 0 : oc + 1;
      up_prev <= up_now; off_prev <= off_now; oe_prev <= rom_oe_n;
   end
   always_comb begin
      if (rom_ce_n || rom_oe_n || rc < TR - 1 || pc < TP - 1 || oc < TO - 1) rom_q = 16'hBAD0;
      else if (rom_wide) rom_q = wsel;
      else rom_q = {1'b1, 7'h55, rom_lsb ? wsel[15:8] : wsel[7:0]};
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         chk(1'b0, "watchdog", wd, 150000);
         finish_run();
      end
   end

   task automatic burst(input int start, input int len, input bit bmode);
      int cyc, loc, expw;
      logic [15:0] expd, sd;
      logic [RAW-1:0] sa;
      logic sl;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = (RAW+1)'(start); req_len = LEN_W'(len); req_byte = bmode;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!rom_ce_n && !rom_oe_n && !req_ready, "R2", {rom_ce_n, rom_oe_n, req_ready}, 0);
      for (int b = 0; b <= len; b++) begin
         loc = start + b;
         if (b == 0) expw = TF;
         else if (bmode) expw = (((loc - 1) % 16) == 15) ? TR : TP;
         else expw = (((loc - 1) % 8) == 7) ? TR : TP;
         cyc = 0;
         while (!out_valid) begin @(negedge clk); cyc++; end
         chk(cyc == expw, (b == 0) ? "R3" : (expw == TR ? "R5" : "R4"), cyc, expw);
         if (bmode) begin
            expd = {8'h00, ((loc / 2) % 2 == 0 || 1) ? ((loc % 2) ? wval(loc / 2) >> 8 : wval(loc / 2) & 16'hFF) : 16'h0};
            chk(!rom_wide && rom_lsb_en && rom_addr == RAW'((loc / 2) % (1 << RAW)) && rom_lsb == loc[0],
                "R7 R8", {rom_wide, rom_lsb_en, rom_lsb, rom_addr}, {1'b0, 1'b1, loc[0], RAW'(loc / 2)});
            chk(out_data == expd, "R7", out_data, expd);
         end else begin
            expd = wval(loc);
            chk(rom_wide && !rom_lsb_en && rom_addr == RAW'(loc % (1 << RAW)),
                "R6 R8", {rom_wide, rom_lsb_en, rom_addr}, {1'b1, 1'b0, RAW'(loc)});
            chk(out_data == expd, "R6", out_data, expd);
         end
         chk(out_last == (b == len), "R9", out_last, b == len);
         if (b % 5 == 2) begin
            sd = out_data; sa = rom_addr; sl = out_last;
            for (int s = 0; s < 3; s++) begin
               @(negedge clk);
               chk(out_valid && out_data == sd && rom_addr == sa && out_last == sl, "R10",
                   out_data, sd);
            end
         end
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
      end
      chk(rom_ce_n && rom_oe_n && !req_ready, "R11", {rom_ce_n, rom_oe_n, req_ready}, 6);
      for (int i = 1; i <= TH; i++) begin
         @(negedge clk);
         chk(req_ready == (i == TH), "R11", req_ready, i == TH);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(rom_ce_n && rom_oe_n && !out_valid && !req_ready, "R1",
          {rom_ce_n, rom_oe_n, out_valid, req_ready}, 12);
      rst_n = 1'b1;
      for (int i = 1; i <= TH; i++) begin
         @(negedge clk);
         chk(req_ready == (i == TH) && rom_ce_n && !out_valid, "R1", req_ready, i == TH);
      end
      burst(5, 0, 1'b0);
      for (int s = 0; s < 8; s++) burst(s, 19, 1'b0);
      burst(60, 9, 1'b0);
      for (int s = 0; s < 16; s++) burst(s + 16, 19, 1'b1);
      burst(124, 9, 1'b1);
      burst(3, 0, 1'b1);
      finish_run();
   end

endmodule